// File: doc/BRIEF.md
# Binary Block Full-Search Motion Estimator

This block finds the best match for a 16x16 block of one-bit pixels inside a search window around it. Every candidate displacement from -16 to +15 pixels, both horizontally and vertically, is scored by its sum of absolute differences (SAD), which for binary pixels is the number of positions where the two blocks differ. The block reports the smallest SAD found and the displacement that produced it.

The current block and the search window sit in small register stores loaded through two write ports while the block is idle. After a start pulse the address generator reads one current-block row and one 32-bit window word, made of two neighbouring 16-bit words, per cycle. Sixteen SAD engines each take their own 16-bit slice of that word, one bit further right per engine, so sixteen horizontally adjacent candidates are scored together in 16 cycles. A selection stage holds each batch of sixteen totals and walks them one per cycle while the next batch accumulates, keeping the running best.

Top module: `bme_search`

## Requirements
- R1: Pixel column c of window row y is bit 15-(c mod 16) of window word (y, c/16); current-block row r, pixel j is bit 15-j of current word r. Candidate (dx, dy) matches current row r, pixel j against window row r+dy+16, column j+dx+16.
- R2: The SAD of a candidate counts differing pixels over all 256 positions; the reported SAD is the minimum over all 1024 candidates and never exceeds 256.
- R3: Candidates are visited with dy ascending and, within a dy, dx ascending; on equal SAD the first visited wins, so uniform data reports dx = dy = -16.
- R4: done is high for exactly one cycle, and the result stays unchanged after it until the next start.
- R5: The cycle after start is sampled, the reported SAD is 256 and done is low.
- R6: Out of reset, done is low, the SAD reads 256 and both offsets read 0.
- R7: dx and dy are 6-bit two's complement values within -16 to +15.
- R8: A start during a search abandons it; only the search begun by the latest start reports.
- R9: done rises on the 1041st rising edge after the edge that samples start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a search; restarts one in progress |
| curWe | input | 1 | Write enable, current-block store |
| curWrRow | input | 4 | Current-block row to write |
| curWrData | input | 16 | Current-block row pixels, leftmost in bit 15 |
| saWe | input | 1 | Write enable, search-window store |
| saWrRow | input | 6 | Window row to write (0 to 47) |
| saWrWord | input | 2 | 16-pixel word within the row (0 to 2) |
| saWrData | input | 16 | Window word pixels, leftmost in bit 15 |
| bestSad | output | 9 | Minimum SAD |
| bestDx | output | 6 | Horizontal offset of the best match |
| bestDy | output | 6 | Vertical offset of the best match |
| done | output | 1 | One-cycle pulse when the result is final |

## Verification
The assertions watch, every cycle, that done never lasts two cycles, that start resets the reported minimum to 256, that the minimum never rises between starts and that reported offsets stay within the search range. Whether the chosen candidate is the right one, including tie resolution, slice dispatch to each engine and restart behaviour, only shows against the bench's independent full-search model over random, planted, all-zero and all-one blocks. The exact completion latency and the holding of the result after done are also bench checks.

// File: rtl/bme_pkg.sv
package bme_pkg;
  localparam int BLK      = 16;                     // block width and height, engine count
  localparam int RANGE    = 16;                     // search from -RANGE to RANGE-1
  localparam int SA_ROWS  = BLK + 2 * RANGE;        // window rows held
  localparam int SA_WORDS = (BLK + 2 * RANGE) / BLK;// words per window row
  localparam int N_BATCH  = 2 * RANGE / BLK;        // engine batches per dy
  localparam int N_DY     = 2 * RANGE;
  localparam int ACC_W    = $clog2(BLK * BLK + 1);
  localparam int CNT_W    = $clog2(BLK + 1);
  localparam int ROW_W    = $clog2(BLK);
  localparam int DY_W     = $clog2(N_DY);
  localparam int BATCH_W  = (N_BATCH > 1) ? $clog2(N_BATCH) : 1;
  localparam int SAR_W    = $clog2(SA_ROWS);
  localparam int WSEL_W   = $clog2(SA_WORDS);
  localparam int VEC_W    = $clog2(RANGE) + 2;
  localparam int SAD_MAX  = BLK * BLK;

  typedef struct packed {
    logic              clear;
    logic              rdEn;
    logic [SAR_W-1:0]  saRow;
    logic [WSEL_W-1:0] wordSel;
    logic [ROW_W-1:0]  curRow;
    logic              first;
    logic              last;
    logic              finalBatch;
    logic [VEC_W-1:0]  baseDx;
    logic [VEC_W-1:0]  baseDy;
  } ctrl_t;
endpackage

// File: rtl/bme_ctrl.sv
module bme_ctrl
  import bme_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  output ctrl_t ctl
);
  logic               running;
  logic [DY_W-1:0]    dyIdx;
  logic [BATCH_W-1:0] batch;
  logic [ROW_W-1:0]   row;

  wire lastRow   = (row == ROW_W'(BLK - 1));
  wire lastBatch = (batch == BATCH_W'(N_BATCH - 1));
  wire lastDy    = (dyIdx == DY_W'(N_DY - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      dyIdx   <= '0;
      batch   <= '0;
      row     <= '0;
    end else if (start) begin
      running <= 1'b1;
      dyIdx   <= '0;
      batch   <= '0;
      row     <= '0;
    end else if (running) begin
      row <= row + 1'b1;
      if (lastRow) begin
        row <= '0;
        if (lastBatch) begin
          batch <= '0;
          if (lastDy) running <= 1'b0;
          else        dyIdx   <= dyIdx + 1'b1;
        end else begin
          batch <= batch + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.clear      = start;
    ctl.rdEn       = running && !start;
    ctl.saRow      = SAR_W'(dyIdx) + SAR_W'(row);
    ctl.wordSel    = WSEL_W'(batch);
    ctl.curRow     = row;
    ctl.first      = (row == '0);
    ctl.last       = lastRow;
    ctl.finalBatch = lastDy && lastBatch;
    ctl.baseDx     = VEC_W'(batch) * VEC_W'(BLK) - VEC_W'(RANGE);
    ctl.baseDy     = VEC_W'(dyIdx) - VEC_W'(RANGE);
  end
endmodule

// File: rtl/bme_sad_engine.sv
module bme_sad_engine
  import bme_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic             first,
  input  logic [BLK-1:0]   curRow,
  input  logic [BLK-1:0]   candRow,
  output logic [ACC_W-1:0] runSum
);
  logic [ACC_W-1:0] acc;
  logic [BLK-1:0]   diff;
  logic [CNT_W-1:0] ones;

  always_comb begin
    diff = curRow ^ candRow;
    ones = '0;
    for (int k = 0; k < BLK; k++) ones = ones + CNT_W'(diff[k]);
    runSum = (first ? '0 : acc) + ACC_W'(ones);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) acc <= '0;
    else if (en)      acc <= runSum;
  end
endmodule

// File: rtl/bme_datapath.sv
module bme_datapath
  import bme_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctl,
  input  logic              curWe,
  input  logic [ROW_W-1:0]  curWrRow,
  input  logic [BLK-1:0]    curWrData,
  input  logic              saWe,
  input  logic [SAR_W-1:0]  saWrRow,
  input  logic [WSEL_W-1:0] saWrWord,
  input  logic [BLK-1:0]    saWrData,
  output logic [ACC_W-1:0]  bestSad,
  output logic [VEC_W-1:0]  bestDx,
  output logic [VEC_W-1:0]  bestDy,
  output logic              done
);
  logic [BLK-1:0] curMem [BLK];
  logic [BLK-1:0] saMem  [SA_ROWS][SA_WORDS];

  always_ff @(posedge clk) begin
    if (curWe) curMem[curWrRow] <= curWrData;
    if (saWe && (int'(saWrRow) < SA_ROWS) && (int'(saWrWord) < SA_WORDS))
      saMem[saWrRow][saWrWord] <= saWrData;
  end

  // read stage
  logic               s1Valid, s1First, s1Last, s1Final;
  logic [2*BLK-1:0]   s1Word;
  logic [BLK-1:0]     s1Cur;
  logic [VEC_W-1:0]   s1Dx, s1Dy;

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) s1Valid <= 1'b0;
    else                  s1Valid <= ctl.rdEn;
    s1Word  <= {saMem[ctl.saRow][ctl.wordSel], saMem[ctl.saRow][ctl.wordSel + 1'b1]};
    s1Cur   <= curMem[ctl.curRow];
    s1First <= ctl.first;
    s1Last  <= ctl.last;
    s1Final <= ctl.finalBatch;
    s1Dx    <= ctl.baseDx;
    s1Dy    <= ctl.baseDy;
  end

  // engine array: engine i sees bits [2*BLK-1-i : BLK-i]
  logic [ACC_W-1:0] sums [BLK];

  for (genvar i = 0; i < BLK; i++) begin : g_engine
    bme_sad_engine u_eng (
      .clk    (clk),
      .rst    (rst),
      .clear  (ctl.clear),
      .en     (s1Valid),
      .first  (s1First),
      .curRow (s1Cur),
      .candRow(s1Word[2*BLK-1-i -: BLK]),
      .runSum (sums[i])
    );
  end

  // compare-and-select
  logic [ACC_W-1:0] sadReg [BLK];
  logic [VEC_W-1:0] tagDx, tagDy;
  logic             tagFinal;
  logic             scanActive, bestValid;
  logic [ROW_W-1:0] scanIdx;

  wire              latchBatch = s1Valid && s1Last;
  wire [ACC_W-1:0]  candSad    = sadReg[scanIdx];
  wire              better     = !bestValid || (candSad < bestSad);
  wire              scanEnd    = (scanIdx == ROW_W'(BLK - 1));

  always_ff @(posedge clk) begin
    if (latchBatch) begin
      for (int i = 0; i < BLK; i++) sadReg[i] <= sums[i];
      tagDx    <= s1Dx;
      tagDy    <= s1Dy;
      tagFinal <= s1Final;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      scanActive <= 1'b0;
      scanIdx    <= '0;
      bestValid  <= 1'b0;
      bestSad    <= ACC_W'(SAD_MAX);
      bestDx     <= '0;
      bestDy     <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (scanActive && better) begin
        bestValid <= 1'b1;
        bestSad   <= candSad;
        bestDx    <= tagDx + VEC_W'(scanIdx);
        bestDy    <= tagDy;
      end
      if (scanActive && scanEnd && tagFinal) done <= 1'b1;
      if (latchBatch) begin
        scanActive <= 1'b1;
        scanIdx    <= '0;
      end else if (scanActive) begin
        if (scanEnd) scanActive <= 1'b0;
        scanIdx <= scanIdx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bme_search.sv
module bme_search
  import bme_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              curWe,
  input  logic [ROW_W-1:0]  curWrRow,
  input  logic [BLK-1:0]    curWrData,
  input  logic              saWe,
  input  logic [SAR_W-1:0]  saWrRow,
  input  logic [WSEL_W-1:0] saWrWord,
  input  logic [BLK-1:0]    saWrData,
  output logic [ACC_W-1:0]  bestSad,
  output logic [VEC_W-1:0]  bestDx,
  output logic [VEC_W-1:0]  bestDy,
  output logic              done
);
  ctrl_t ctl;

  bme_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .ctl  (ctl)
  );

  bme_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .curWe    (curWe),
    .curWrRow (curWrRow),
    .curWrData(curWrData),
    .saWe     (saWe),
    .saWrRow  (saWrRow),
    .saWrWord (saWrWord),
    .saWrData (saWrData),
    .bestSad  (bestSad),
    .bestDx   (bestDx),
    .bestDy   (bestDy),
    .done     (done)
  );
endmodule

// File: rtl/bme_search_chk.sv
module bme_search_chk
  import bme_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [ACC_W-1:0] bestSad,
  input logic [VEC_W-1:0] bestDx,
  input logic [VEC_W-1:0] bestDy,
  input logic             done
);
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_start_clear_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> (bestSad == ACC_W'(SAD_MAX) && !done));

  assert_min_falls_R2: assert property (@(posedge clk) disable iff (rst)
    !start |=> (bestSad <= $past(bestSad)));

  assert_sad_bound_R2: assert property (@(posedge clk) disable iff (rst)
    bestSad <= ACC_W'(SAD_MAX));

  assert_vec_range_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($signed(bestDx) >= -RANGE && $signed(bestDx) <= RANGE - 1 &&
              $signed(bestDy) >= -RANGE && $signed(bestDy) <= RANGE - 1));
endmodule

bind bme_search bme_search_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .bestSad(bestSad),
  .bestDx (bestDx),
  .bestDy (bestDy),
  .done   (done)
);

// File: tb/bme_search_bench.sv
module bme_search_bench;
  import bme_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              curWe = 1'b0;
  logic [ROW_W-1:0]  curWrRow = '0;
  logic [BLK-1:0]    curWrData = '0;
  logic              saWe = 1'b0;
  logic [SAR_W-1:0]  saWrRow = '0;
  logic [WSEL_W-1:0] saWrWord = '0;
  logic [BLK-1:0]    saWrData = '0;
  logic [ACC_W-1:0]  bestSad;
  logic [VEC_W-1:0]  bestDx, bestDy;
  logic              done;

  always #10 clk = ~clk;

  bme_search u_bme_search (.*);

  int total = 0;
  int bad = 0;

  // scenario table: {kind, seed, planted dx, planted dy}
  // kind 0 random, 1 planted copy, 2 all zero, 3 ones vs zeros, 4 all ones, 5 sparse
  localparam int NSC = 9;
  localparam logic [47:0] SCEN [NSC] = '{
    {4'd0, 32'h0000_1234, 6'h00, 6'h00},
    {4'd1, 32'h0000_0007, 6'h03, 6'h3B},
    {4'd1, 32'h0000_0009, 6'h30, 6'h30},
    {4'd1, 32'h0000_000B, 6'h0F, 6'h0F},
    {4'd2, 32'h0000_0001, 6'h00, 6'h00},
    {4'd3, 32'h0000_0001, 6'h00, 6'h00},
    {4'd4, 32'h0000_0001, 6'h00, 6'h00},
    {4'd5, 32'h00C0_FFEE, 6'h00, 6'h00},
    {4'd1, 32'h0BAD_5EED, 6'h38, 6'h05}
  };

  logic [BLK-1:0] mCur [BLK];
  logic [BLK-1:0] mSa  [SA_ROWS][SA_WORDS];
  logic [31:0]    rng;
  int             expSad, expDx, expDy;

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic saPix(input int y, input int c);
    return mSa[y][c / BLK][BLK - 1 - (c % BLK)];
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic build(input logic [3:0] kind, input logic [31:0] seed,
                       input int pdx, input int pdy);
    rng = (seed == 0) ? 32'h1 : seed;
    for (int y = 0; y < SA_ROWS; y++)
      for (int w = 0; w < SA_WORDS; w++) begin
        rng = nextRand(rng);
        case (kind)
          4'd2, 4'd3: mSa[y][w] = '0;
          4'd4:       mSa[y][w] = '1;
          4'd5: begin
            logic [15:0] t = rng[15:0];
            rng = nextRand(rng);
            mSa[y][w] = t & rng[15:0];
          end
          default:    mSa[y][w] = rng[15:0];
        endcase
      end
    for (int r = 0; r < BLK; r++) begin
      rng = nextRand(rng);
      case (kind)
        4'd1: for (int j = 0; j < BLK; j++)
                mCur[r][BLK - 1 - j] = saPix(r + pdy + RANGE, j + pdx + RANGE);
        4'd2: mCur[r] = '0;
        4'd3, 4'd4: mCur[r] = '1;
        4'd5: mCur[r] = rng[31:16] & rng[15:0];
        default: mCur[r] = rng[15:0];
      endcase
    end
  endtask

  task automatic model();
    expSad = SAD_MAX + 1;
    for (int dy = -RANGE; dy < RANGE; dy++)
      for (int dx = -RANGE; dx < RANGE; dx++) begin
        int s = 0;
        for (int r = 0; r < BLK; r++)
          for (int j = 0; j < BLK; j++)
            if (mCur[r][BLK - 1 - j] != saPix(r + dy + RANGE, j + dx + RANGE)) s++;
        if (s < expSad) begin
          expSad = s; expDx = dx; expDy = dy;
        end
      end
  endtask

  task automatic load();
    for (int y = 0; y < SA_ROWS; y++)
      for (int w = 0; w < SA_WORDS; w++) begin
        @(negedge clk);
        saWe = 1'b1; saWrRow = SAR_W'(y); saWrWord = WSEL_W'(w); saWrData = mSa[y][w];
      end
    @(negedge clk);
    saWe = 1'b0;
    for (int r = 0; r < BLK; r++) begin
      curWe = 1'b1; curWrRow = ROW_W'(r); curWrData = mCur[r];
      @(negedge clk);
    end
    curWe = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done; returns edges counted since the start-sampling edge
  task automatic waitDone(output int edges);
    edges = 0;
    while (!done && edges < 3000) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic checkResult(input string tag);
    check(bestSad == ACC_W'(expSad), {"R2 sad ", tag}, int'(bestSad), expSad);
    check(int'($signed(bestDx)) == expDx, {"R1 R3 dx ", tag}, int'($signed(bestDx)), expDx);
    check(int'($signed(bestDy)) == expDy, {"R1 R3 dy ", tag}, int'($signed(bestDy)), expDy);
    check($signed(bestDx) >= -RANGE && $signed(bestDx) < RANGE, {"R7 range ", tag},
          int'($signed(bestDx)), 0);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int edges;
    logic [ACC_W-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    check(!done, "R6 done", int'(done), 0);
    check(bestSad == ACC_W'(SAD_MAX), "R6 sad", int'(bestSad), SAD_MAX);
    check(bestDx == '0 && bestDy == '0, "R6 vec", int'(bestDx), 0);

    for (int s = 0; s < NSC; s++) begin
      build(SCEN[s][47:44], SCEN[s][43:12],
            int'($signed(SCEN[s][11:6])), int'($signed(SCEN[s][5:0])));
      model();
      load();
      pulseStart();
      // R5: first negedge after the start edge
      check(bestSad == ACC_W'(SAD_MAX) && !done, "R5 start clears", int'(bestSad), SAD_MAX);
      waitDone(edges);
      check(edges == 1041, "R9 latency", edges, 1041);
      checkResult($sformatf("scenario %0d", s));
      held = bestSad;
      @(negedge clk);
      check(!done, "R4 pulse width", int'(done), 0);
      repeat (8) @(negedge clk);
      check(bestSad == held && !done, "R4 hold", int'(bestSad), int'(held));
    end

    // R8: restart mid-search on new data
    build(4'd1, 32'h0000_5A5A, -7, 9);
    model();
    load();
    pulseStart();
    repeat (400) @(negedge clk);
    pulseStart();
    waitDone(edges);
    check(edges == 1041, "R8 restart latency", edges, 1041);
    checkResult("R8 restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule